// File: doc/BRIEF.md
# Chain Command Frame Encoder

This block turns a command request into the byte stream that is sent down a serial chip chain. Each request names a frame class, a type byte, a target chip address and up to `MAX_PAY` payload bytes. The block accepts the request and stores it. It then emits a two-byte sync pattern, the type, a length byte, the address and the payload. It closes the frame with a check code. A short command frame carries a 5-bit CRC and a job frame carries a 16-bit CRC.

The output is a byte stream under a valid/ready handshake. The downstream side may stall at any byte. A new request is taken only when the encoder is idle, which happens after the final byte of the current frame has been consumed. UART bit serialisation is done elsewhere.

Top module: `cfe_frame_encoder`

## Requirements
- R1: After reset, `out_valid` is low and `req_ready` is high.
- R2: Every frame starts with byte 0x55 and then byte 0xAA.
- R3: After the sync pair, the frame carries the type byte, the length byte, the address byte, the payload bytes and then the CRC byte(s), in that order.
- R4: The length byte equals 3 + payload count + CRC byte count. The CRC byte count is 1 for a short frame (`req_kind`=0) and 2 for a job frame (`req_kind`=1). The sync pair is not counted.
- R5: A short frame ends with one CRC byte. Bits [4:0] of that byte hold a CRC-5 and bits [7:5] are zero. The CRC-5 uses polynomial x^5+x^2+1 and starts from 5'h1F. Each byte is processed most significant bit first, from the type byte to the last payload byte.
- R6: A job frame ends with two CRC bytes, high byte first. The CRC is a CRC-16 with polynomial 0x1021 and start value 0xFFFF. It processes the same bytes as in R5, most significant bit first, with no reflection and no final XOR.
- R7: The address byte is emitted exactly as requested. The value 0x00 means broadcast and is sent unchanged.
- R8: `req_ready` stays low from the cycle after a request is accepted until the final byte has been taken. A request presented during that time has no effect on the stream. `out_last` is high only on the final byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged in the next cycle.
- R10: Payload byte i is taken from `req_payload[8*i+7:8*i]`, and byte 0 is sent first. With a count of zero, the CRC follows the address directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder idle, request taken this cycle |
| req_kind | input | 1 | 0 = short command frame, 1 = job frame |
| req_type | input | 8 | Type byte |
| req_addr | input | 8 | Chip address, 0x00 for broadcast |
| req_count | input | CW | Payload byte count, 0..MAX_PAY |
| req_payload | input | 8*MAX_PAY | Payload bytes, byte 0 in the low bits |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The assertions rely on one input rule: whenever `req_valid` is high, `req_count` does not exceed `MAX_PAY`. The length and final-position checks depend on that rule, and a property checks that it holds. The stimulus sweeps every count from zero to `MAX_PAY` for both frame classes and never goes past that bound. `out_ready` carries no assumption. The stimulus drives it high throughout, or pseudo-randomly, and it may also present an unrelated request while a frame is still being sent.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SYNC0,
    ST_SYNC1,
    ST_TYPE,
    ST_LEN,
    ST_ADDR,
    ST_PAY,
    ST_CRC_A,
    ST_CRC_B
  } cfe_state_e;

  typedef enum logic {
    KIND_SHORT = 1'b0,
    KIND_JOB   = 1'b1
  } cfe_kind_e;

  localparam logic [7:0] SYNC_FIRST  = 8'h55;
  localparam logic [7:0] SYNC_SECOND = 8'hAA;

  localparam int CRC5_W = 5;
  localparam logic [CRC5_W-1:0] CRC5_POLY = 5'h05;
  localparam logic [CRC5_W-1:0] CRC5_SEED = 5'h1F;

  localparam int CRC16_W = 16;
  localparam logic [CRC16_W-1:0] CRC16_POLY = 16'h1021;
  localparam logic [CRC16_W-1:0] CRC16_SEED = 16'hFFFF;

endpackage

// File: rtl/cfe_crc_engine.sv
module cfe_crc_engine #(
  parameter int W = 5,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic [W-1:0] stepped;

  // One byte, most significant bit first, per enabled cycle
  always_comb begin
    logic fb;
    stepped = crc_q;
    for (int i = 7; i >= 0; i--) begin
      fb      = stepped[W-1] ^ din[i];
      stepped = {stepped[W-2:0], 1'b0};
      if (fb) begin
        stepped = stepped ^ POLY;
      end
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr) begin
      crc_d = SEED;
    end else if (en) begin
      crc_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= SEED;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/cfe_pay_sel.sv
module cfe_pay_sel #(
  parameter int N = 8,
  localparam int IW = $clog2(N + 1)
) (
  input  logic [N*8-1:0] vec,
  input  logic [IW-1:0]  idx,
  output logic [7:0]     sel
);

  logic [7:0] lane [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane[g] = vec[g*8 +: 8];
  end

  always_comb begin
    sel = '0;
    for (int g = 0; g < N; g++) begin
      if (idx == IW'(g)) begin
        sel = lane[g];
      end
    end
  end

endmodule

// File: rtl/cfe_seq.sv
module cfe_seq
  import cfe_pkg::*;
#(
  parameter int MAX_PAY = 8,
  localparam int CW = $clog2(MAX_PAY + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_kind,
  input  logic [7:0]            req_type,
  input  logic [7:0]            req_addr,
  input  logic [CW-1:0]         req_count,
  input  logic [MAX_PAY*8-1:0]  req_payload,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data,
  output logic                  out_last,
  output logic                  crc_clr,
  output logic                  crc_en,
  input  logic [CRC5_W-1:0]     crc5_val,
  input  logic [CRC16_W-1:0]    crc16_val
);

  cfe_state_e           state_q, state_d;
  cfe_kind_e            kind_q, kind_d;
  logic [7:0]           type_q, type_d;
  logic [7:0]           addr_q, addr_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [CW-1:0]        idx_q, idx_d;
  logic [MAX_PAY*8-1:0] pay_q, pay_d;

  logic       accept;
  logic       fire;
  logic       last_pay;
  logic [7:0] len_byte;
  logic [7:0] pay_byte;

  cfe_pay_sel #(.N(MAX_PAY)) u_pay_sel (
    .vec (pay_q),
    .idx (idx_q),
    .sel (pay_byte)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign out_valid = (state_q != ST_IDLE);
  assign fire      = out_valid && out_ready;
  assign last_pay  = (idx_q == cnt_q - CW'(1));
  assign len_byte  = 8'(cnt_q) + 8'd3 + ((kind_q == KIND_JOB) ? 8'd2 : 8'd1);

  // Next-state and capture logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    type_d  = type_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    pay_d   = pay_q;
    idx_d   = idx_q;
    if (accept) begin
      kind_d  = cfe_kind_e'(req_kind);
      type_d  = req_type;
      addr_d  = req_addr;
      cnt_d   = req_count;
      pay_d   = req_payload;
      idx_d   = '0;
      state_d = ST_SYNC0;
    end else if (fire) begin
      unique case (state_q)
        ST_SYNC0: state_d = ST_SYNC1;
        ST_SYNC1: state_d = ST_TYPE;
        ST_TYPE:  state_d = ST_LEN;
        ST_LEN:   state_d = ST_ADDR;
        ST_ADDR:  state_d = (cnt_q == '0) ? ST_CRC_A : ST_PAY;
        ST_PAY: begin
          idx_d = idx_q + CW'(1);
          if (last_pay) begin
            state_d = ST_CRC_A;
          end
        end
        ST_CRC_A: state_d = (kind_q == KIND_JOB) ? ST_CRC_B : ST_IDLE;
        ST_CRC_B: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  // Output byte selection
  always_comb begin
    out_data = '0;
    out_last = 1'b0;
    unique case (state_q)
      ST_SYNC0: out_data = SYNC_FIRST;
      ST_SYNC1: out_data = SYNC_SECOND;
      ST_TYPE:  out_data = type_q;
      ST_LEN:   out_data = len_byte;
      ST_ADDR:  out_data = addr_q;
      ST_PAY:   out_data = pay_byte;
      ST_CRC_A: begin
        if (kind_q == KIND_JOB) begin
          out_data = crc16_val[15:8];
        end else begin
          out_data = {3'b000, crc5_val};
          out_last = 1'b1;
        end
      end
      ST_CRC_B: begin
        out_data = crc16_val[7:0];
        out_last = 1'b1;
      end
      default: out_data = '0;
    endcase
  end

  assign crc_clr = accept;
  assign crc_en  = fire && (state_q == ST_TYPE || state_q == ST_LEN ||
                            state_q == ST_ADDR || state_q == ST_PAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_SHORT;
      type_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      pay_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      type_q  <= type_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      pay_q   <= pay_d;
    end
  end

endmodule

// File: rtl/cfe_frame_encoder.sv
module cfe_frame_encoder
  import cfe_pkg::*;
#(
  parameter int MAX_PAY = 8,
  localparam int CW = $clog2(MAX_PAY + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_kind,
  input  logic [7:0]           req_type,
  input  logic [7:0]           req_addr,
  input  logic [CW-1:0]        req_count,
  input  logic [MAX_PAY*8-1:0] req_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_last
);

  logic                 crc_clr;
  logic                 crc_en;
  logic [CRC5_W-1:0]    crc5_val;
  logic [CRC16_W-1:0]   crc16_val;

  cfe_seq #(.MAX_PAY(MAX_PAY)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .req_type    (req_type),
    .req_addr    (req_addr),
    .req_count   (req_count),
    .req_payload (req_payload),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .crc_clr     (crc_clr),
    .crc_en      (crc_en),
    .crc5_val    (crc5_val),
    .crc16_val   (crc16_val)
  );

  cfe_crc_engine #(
    .W    (CRC5_W),
    .POLY (CRC5_POLY),
    .SEED (CRC5_SEED)
  ) u_crc5 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (out_data),
    .crc   (crc5_val)
  );

  cfe_crc_engine #(
    .W    (CRC16_W),
    .POLY (CRC16_POLY),
    .SEED (CRC16_SEED)
  ) u_crc16 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (out_data),
    .crc   (crc16_val)
  );

endmodule

// File: rtl/cfe_frame_checker.sv
module cfe_frame_checker #(
  parameter int MAX_PAY = 8,
  localparam int CW = $clog2(MAX_PAY + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_kind,
  input logic [CW-1:0] req_count,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last
);

  logic [7:0]    pos_q;
  logic [CW-1:0] cnt_c;
  logic          kind_c;
  logic [7:0]    exp_len;

  assign exp_len = 8'(cnt_c) + 8'd3 + (kind_c ? 8'd2 : 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      cnt_c  <= '0;
      kind_c <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        cnt_c  <= req_count;
        kind_c <= req_kind;
      end
      if (out_valid && out_ready) begin
        pos_q <= out_last ? 8'd0 : pos_q + 8'd1;
      end
    end
  end

  // input rule relied on by the length checks (R4)
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_count <= CW'(MAX_PAY)));

  a_r2_first_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos_q == 8'd0) |-> (out_data == 8'h55));

  a_r2_second_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos_q == 8'd1) |-> (out_data == 8'hAA));

  a_r4_length_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos_q == 8'd3) |-> (out_data == exp_len));

  a_r8_last_position: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (pos_q == exp_len + 8'd1));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  a_r5_crc5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && !kind_c) |-> (out_data[7:5] == 3'b000));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind cfe_frame_encoder cfe_frame_checker #(.MAX_PAY(MAX_PAY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_count (req_count),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tb_cfe_frame_encoder.sv
`timescale 1ns/1ps
module tb_cfe_frame_encoder;

  localparam int MAXP = 8;
  localparam int CW   = $clog2(MAXP + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_kind;
  logic [7:0]        req_type;
  logic [7:0]        req_addr;
  logic [CW-1:0]     req_count;
  logic [MAXP*8-1:0] req_payload;
  logic              out_valid;
  logic              out_ready;
  logic [7:0]        out_data;
  logic              out_last;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  cfe_frame_encoder #(.MAX_PAY(MAXP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_type(req_type), .req_addr(req_addr), .req_count(req_count),
    .req_payload(req_payload),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_crc5(input logic [4:0] c, input logic [7:0] b);
    logic [4:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[4] != b[i]) r = (r << 1) ^ 5'b00101;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_crc16(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] != b[i]) r = (r << 1) ^ 16'h1021;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic string tag_for(input int k, input int cnt, input int n, input bit kind);
    if (k < 2) return "R2";
    if (k == 3) return "R4";
    if (k == 4) return "R7";
    if (k >= 5 && k < 5 + cnt) return "R10";
    if (k >= n - (kind ? 2 : 1)) return kind ? "R6" : "R5";
    return "R3";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_frame(input bit kind, input int cnt, input int pat);
    logic [7:0] exp [0:31];
    logic [7:0] ty, ad;
    logic [MAXP*8-1:0] pay;
    logic [4:0]  c5;
    logic [15:0] c16;
    int n, k, guard;
    bit stalled;
    logic [7:0] held_d;
    logic held_l;
    ty  = 8'(8'h40 + cnt * 3 + (kind ? 8'h80 : 8'h00) + pat);
    ad  = (pat == 0) ? 8'h00 : 8'(cnt * 17 + 1);
    pay = '0;
    for (int i = 0; i < MAXP; i++) pay[i*8 +: 8] = 8'(i * 37 + cnt * 11 + pat * 5 + 3);
    n = 5 + cnt + (kind ? 2 : 1);
    exp[0] = 8'h55;
    exp[1] = 8'hAA;
    exp[2] = ty;
    exp[3] = 8'(n - 2);
    exp[4] = ad;
    for (int i = 0; i < cnt; i++) exp[5 + i] = pay[i*8 +: 8];
    c5  = 5'h1F;
    c16 = 16'hFFFF;
    for (int i = 2; i < 5 + cnt; i++) begin
      c5  = ref_crc5(c5, exp[i]);
      c16 = ref_crc16(c16, exp[i]);
    end
    if (kind) begin
      exp[n-2] = c16[15:8];
      exp[n-1] = c16[7:0];
    end else begin
      exp[n-1] = {3'b000, c5};
    end

    @(negedge clk);
    check(req_ready === 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid   = 1'b1;
    req_kind    = kind;
    req_type    = ty;
    req_addr    = ad;
    req_count   = CW'(cnt);
    req_payload = pay;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    guard = 0;
    stalled = 1'b0;
    held_d = '0;
    held_l = 1'b0;
    while (k < n && guard < 2000) begin
      if (stalled) begin
        check(out_valid === 1'b1 && out_data === held_d && out_last === held_l,
              "R9 hold under stall", int'(out_data), int'(held_d));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (pat == 0) ? 1'b1 : lfsr[0];
      if (pat == 2 && k > 2 && k < n - 1) begin
        req_valid = 1'b1;
        req_type  = 8'hEE;
        req_addr  = 8'hEE;
        req_count = CW'(MAXP);
      end else begin
        req_valid = 1'b0;
      end
      if (out_valid) begin
        check(req_ready === 1'b0, "R8 busy not ready", int'(req_ready), 0);
      end
      if (out_valid && out_ready) begin
        check(out_data === exp[k], tag_for(k, cnt, n, kind), int'(out_data), int'(exp[k]));
        check(out_last === (k == n - 1), "R8 last flag", int'(out_last), int'(k == n - 1));
        k++;
        stalled = 1'b0;
      end else if (out_valid) begin
        stalled = 1'b1;
        held_d  = out_data;
        held_l  = out_last;
      end else begin
        check(1'b0, "R3 byte missing", 0, 1);
      end
      @(negedge clk);
      guard++;
    end
    check(k == n, "R8 frame completes", k, n);
    req_valid = 1'b0;
    out_ready = 1'b0;
    check(out_valid === 1'b0 && req_ready === 1'b1, "R8 idle after last",
          int'({out_valid, req_ready}), 1);
  endtask

  initial begin
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_kind    = 1'b0;
    req_type    = '0;
    req_addr    = '0;
    req_count   = '0;
    req_payload = '0;
    out_ready   = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(req_ready === 1'b1, "R1 reset req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && req_ready === 1'b1, "R1 after release",
          int'({out_valid, req_ready}), 1);
    for (int pat = 0; pat < 3; pat++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int cnt = 0; cnt <= MAXP; cnt++) begin
          run_frame(kind[0], cnt, pat);
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule